// File: doc/BRIEF.md
# Asynchronous Serial Port with Address Filter

This block is a full-duplex asynchronous serial port. Each character on the line has ten bit times: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The bit rate comes from an external rollover tick. The block divides that tick by sixteen, or by thirty-two when the slow select is high. The tick generator itself is not part of this block.

The transmitter accepts a byte through a write strobe. It holds the byte until the next wrap of its free-running sixteen-step phase counter, and only then drives the start bit. It raises a done flag when it places the stop bit on the line. The receiver waits for a high-to-low edge on the synchronized input line. It restarts its own phase count at that edge and takes three samples in the middle of every bit, so that a two-of-three vote decides each bit.

At the middle of the stop bit the receiver decides whether to keep the character. The decision depends on the receive flag, an address-filter mode bit and the stop bit value. A kept character updates the data register, the ninth-bit register and the receive flag. In every case the receiver then goes straight back to waiting for a start edge.

Top module: `async_uart_mp`

## Requirements
- R1: After reset, `ser_out` is 1, `tx_done` is 0 and `rx_done` is 0. Whenever the transmitter has no byte pending or in flight, `ser_out` is 1.
- R2: A transmitted character is a 0 start bit, then `tx_wdata` bits 0 through 7 in that order, then a 1 stop bit. Each bit lasts 16 sub-ticks.
- R3: The transmitter keeps a free-running phase counter that steps on each sub-tick and wraps from 15 to 0. After a write, the start bit is driven in the clock after the next wrap. `ser_out` changes only in the clock after a wrap.
- R4: `tx_done` goes to 1 in the same clock in which the stop bit is driven. A `tx_done_clr` pulse clears it. If a set and a clear fall in the same clock, the set wins.
- R5: A write made while a byte is pending or being sent is ignored. The character in flight is not changed, and no extra character follows it.
- R6: `ser_in` passes through a two-flop synchronizer. A frame starts only on a 1-to-0 transition of the synchronized line while `rx_enable` is 1. With `rx_enable` at 0, no character is received.
- R7: The receiver restarts its phase count at the start edge. It samples the synchronized line at phase counts 7, 8 and 9, and the majority of the three samples is the bit value. A disturbance that hits only one sample does not change the byte.
- R8: If the start bit votes to 1, the receiver drops the frame and goes back to waiting for a falling edge. No flag is raised.
- R9: At the middle of the stop bit, the character is kept only if `rx_done` is 0 and either `rx_filter` is 0, or `rx_filter` is 1 and the stop bit is 1.
- R10: A kept character loads the byte into `rx_data`, loads the stop bit into `rx_ninth` and sets `rx_done`. A dropped character leaves all three unchanged. A `rx_done_clr` pulse clears `rx_done`, and a set in the same clock wins.
- R11: Right after the middle of the stop bit, whether the character was kept or dropped, the receiver is looking for the next start edge. A frame whose start bit begins before the nominal end of the previous stop bit is still received.
- R12: When `slow_sel` is 1, a sub-tick occurs on every second `baud_tick`, so each bit lasts 32 ticks for both transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock rollover pulse from the external rate timer |
| slow_sel | input | 1 | 1 selects divide-by-32, 0 selects divide-by-16 |
| tx_write | input | 1 | Write strobe for the transmit byte |
| tx_wdata | input | 8 | Byte to transmit |
| tx_done_clr | input | 1 | Clears the transmit done flag |
| tx_done | output | 1 | Transmit done flag |
| ser_out | output | 1 | Serial transmit line |
| rx_enable | input | 1 | Allows reception when 1 |
| rx_filter | input | 1 | Address-filter mode: 1 requires a high stop bit |
| rx_done_clr | input | 1 | Clears the receive done flag |
| rx_done | output | 1 | Receive done flag |
| rx_data | output | 8 | Last kept received byte |
| rx_ninth | output | 1 | Stop bit of the last kept character |
| ser_in | input | 1 | Serial receive line |

## Verification
A slip in the transmit phase counter moves the edges on `ser_out` away from the wrap. The per-clock comparison against the bench's reference model flags that at the first edge, at most one bit time after the fault. A wrong transmit bit index shows as a misplaced stop bit, or as `tx_done` rising in the wrong clock, within the same character.

On the receive side, a phase or bit-count error shifts the mid-stop decision clock. That shows as `rx_done`, `rx_data` or `rx_ninth` changing one or more clocks away from the expected clock at the end of the affected frame. A bad acceptance term shows as a flag or data update at that same decision point.

// File: rtl/async_uart_pkg.sv
package async_uart_pkg;

    localparam int unsigned CHAR_BITS   = 8;
    localparam int unsigned OVERSAMPLE  = 16;
    localparam int unsigned VOTE_FIRST  = 7;
    localparam int unsigned SLOW_FACTOR = 2;

    typedef enum logic [1:0] {
        TXS_IDLE = 2'd0,
        TXS_WAIT = 2'd1,
        TXS_SEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        RXS_HUNT  = 1'b0,
        RXS_FRAME = 1'b1
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic keep_char(input logic flag_full, input logic filter_on,
                                       input logic stop_val);
        return ~flag_full & (~filter_on | stop_val);
    endfunction

endpackage

// File: rtl/async_uart_sync.sv
module async_uart_sync #(
    parameter int STAGES = 2,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_LEVEL;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_LEVEL}};
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/async_uart_prescale.sv
module async_uart_prescale #(
    parameter int SLOW_DIV = async_uart_pkg::SLOW_FACTOR
) (
    input  logic clk,
    input  logic rst,
    input  logic baud_tick,
    input  logic slow_sel,
    output logic sub_tick
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          last_slot;

    assign last_slot = (cnt_q == CW'(SLOW_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
        end
    end

    assign sub_tick = baud_tick & (~slow_sel | last_slot);
endmodule

// File: rtl/async_uart_tx.sv
module async_uart_tx
    import async_uart_pkg::*;
#(
    parameter int DATA_W = CHAR_BITS,
    parameter int OVS    = OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_clr,
    output logic              line,
    output logic              done,
    output logic              busy,
    output logic              roll
);
    localparam int PH_W  = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 1);

    tx_state_e         state_q;
    logic [PH_W-1:0]   phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              line_q;
    logic              done_q;
    logic              last_bit;
    logic              set_done;

    assign roll     = sub_tick & (phase_q == PH_W'(OVS - 1));
    assign last_bit = (idx_q == IDX_W'(DATA_W));
    assign set_done = (state_q == TXS_SEND) & roll & last_bit;
    assign busy     = (state_q != TXS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (sub_tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXS_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            line_q  <= 1'b1;
        end else begin
            unique case (state_q)
                TXS_IDLE: begin
                    if (wr_en) begin
                        shreg_q <= wr_data;
                        state_q <= TXS_WAIT;
                    end
                end
                TXS_WAIT: begin
                    if (roll) begin
                        line_q  <= 1'b0;
                        idx_q   <= '0;
                        state_q <= TXS_SEND;
                    end
                end
                TXS_SEND: begin
                    if (roll) begin
                        if (last_bit) begin
                            line_q  <= 1'b1;
                            state_q <= TXS_IDLE;
                        end else begin
                            line_q  <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= TXS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (set_done) done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    assign line = line_q;
    assign done = done_q;
endmodule

// File: rtl/async_uart_rx.sv
module async_uart_rx
    import async_uart_pkg::*;
#(
    parameter int DATA_W    = CHAR_BITS,
    parameter int OVS       = OVERSAMPLE,
    parameter int SAMPLE_AT = VOTE_FIRST,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_tick,
    input  logic              line_in,
    input  logic              enable,
    input  logic              filter_on,
    input  logic              done_clr,
    output logic [DATA_W-1:0] data,
    output logic              ninth,
    output logic              done
);
    localparam int PH_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 2);

    rx_state_e         state_q;
    logic              synced;
    logic              prev_q;
    logic              fall;
    logic [PH_W-1:0]   phase_q;
    logic [BIT_W-1:0]  bit_q;
    logic [1:0]        samp_q;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] data_q;
    logic              ninth_q;
    logic              done_q;
    logic              decide;
    logic              voted;
    logic              at_stop;
    logic              accept;

    async_uart_sync #(.STAGES(SYNC_LEN), .RST_LEVEL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (synced)
    );

    assign fall    = prev_q & ~synced;
    assign decide  = (state_q == RXS_FRAME) & sub_tick & (phase_q == PH_W'(SAMPLE_AT + 2));
    assign voted   = vote3(samp_q[0], samp_q[1], synced);
    assign at_stop = (bit_q == BIT_W'(DATA_W + 1));
    assign accept  = decide & at_stop & keep_char(done_q, filter_on, voted);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= synced;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RXS_HUNT;
            phase_q <= '0;
            bit_q   <= '0;
            samp_q  <= '0;
            shreg_q <= '0;
        end else begin
            unique case (state_q)
                RXS_HUNT: begin
                    if (enable && fall) begin
                        state_q <= RXS_FRAME;
                        phase_q <= '0;
                        bit_q   <= '0;
                    end
                end
                RXS_FRAME: begin
                    if (sub_tick) begin
                        phase_q <= phase_q + 1'b1;
                        if (phase_q == PH_W'(SAMPLE_AT))     samp_q[0] <= synced;
                        if (phase_q == PH_W'(SAMPLE_AT + 1)) samp_q[1] <= synced;
                    end
                    if (decide) begin
                        if (bit_q == '0) begin
                            if (voted) state_q <= RXS_HUNT;
                            else       bit_q   <= bit_q + 1'b1;
                        end else if (!at_stop) begin
                            shreg_q <= {voted, shreg_q[DATA_W-1:1]};
                            bit_q   <= bit_q + 1'b1;
                        end else begin
                            state_q <= RXS_HUNT;
                        end
                    end
                end
                default: state_q <= RXS_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ninth_q <= 1'b0;
        end else if (accept) begin
            data_q  <= shreg_q;
            ninth_q <= voted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (accept)   done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    assign data  = data_q;
    assign ninth = ninth_q;
    assign done  = done_q;
endmodule

// File: rtl/async_uart_mp.sv
module async_uart_mp
    import async_uart_pkg::*;
#(
    parameter int DATA_W    = CHAR_BITS,
    parameter int OVS       = OVERSAMPLE,
    parameter int SAMPLE_AT = VOTE_FIRST,
    parameter int SLOW_DIV  = SLOW_FACTOR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              slow_sel,
    input  logic              tx_write,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_done_clr,
    output logic              tx_done,
    output logic              ser_out,
    input  logic              rx_enable,
    input  logic              rx_filter,
    input  logic              rx_done_clr,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    input  logic              ser_in
);
    logic sub_tick;
    logic tx_busy;
    logic tx_roll;

    async_uart_prescale #(.SLOW_DIV(SLOW_DIV)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .slow_sel  (slow_sel),
        .sub_tick  (sub_tick)
    );

    async_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .sub_tick (sub_tick),
        .wr_en    (tx_write),
        .wr_data  (tx_wdata),
        .done_clr (tx_done_clr),
        .line     (ser_out),
        .done     (tx_done),
        .busy     (tx_busy),
        .roll     (tx_roll)
    );

    async_uart_rx #(.DATA_W(DATA_W), .OVS(OVS), .SAMPLE_AT(SAMPLE_AT)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .sub_tick  (sub_tick),
        .line_in   (ser_in),
        .enable    (rx_enable),
        .filter_on (rx_filter),
        .done_clr  (rx_done_clr),
        .data      (rx_data),
        .ninth     (rx_ninth),
        .done      (rx_done)
    );
endmodule

// File: rtl/async_uart_checks.sv
module async_uart_checks #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_out,
    input logic              tx_done,
    input logic              tx_roll,
    input logic              tx_busy,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ninth
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> ser_out);

    a_r3_line_moves_after_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_out) |-> $past(tx_roll));

    a_r4_flag_with_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> ser_out);

    a_r9_full_holds_data: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> ($stable(rx_data) && $stable(rx_ninth)));

    a_r10_data_only_on_keep: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> $rose(rx_done));

    a_r10_ninth_only_on_keep: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_ninth) |-> $rose(rx_done));
endmodule

bind async_uart_mp async_uart_checks #(.DATA_W(DATA_W)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .ser_out  (ser_out),
    .tx_done  (tx_done),
    .tx_roll  (tx_roll),
    .tx_busy  (tx_busy),
    .rx_done  (rx_done),
    .rx_data  (rx_data),
    .rx_ninth (rx_ninth)
);

// File: tb/tb_async_uart_mp.sv
`timescale 1ns/1ps
module tb_async_uart_mp;
    localparam int TICK_DIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       slow_sel = 1'b0;
    logic       tx_write = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       tx_done_clr = 1'b0;
    logic       tx_done;
    logic       ser_out;
    logic       rx_enable = 1'b0;
    logic       rx_filter = 1'b0;
    logic       rx_done_clr = 1'b0;
    logic       rx_done;
    logic [7:0] rx_data;
    logic       rx_ninth;
    logic       ser_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_cnt = 0;

    async_uart_mp dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .slow_sel(slow_sel),
        .tx_write(tx_write), .tx_wdata(tx_wdata), .tx_done_clr(tx_done_clr),
        .tx_done(tx_done), .ser_out(ser_out), .rx_enable(rx_enable),
        .rx_filter(rx_filter), .rx_done_clr(rx_done_clr), .rx_done(rx_done),
        .rx_data(rx_data), .rx_ninth(rx_ninth), .ser_in(ser_in)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (tick_cnt == TICK_DIV - 1) begin
            tick_cnt  <= 0;
            baud_tick <= 1'b1;
        end else begin
            tick_cnt  <= tick_cnt + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         m_half;
    int         m_tph, m_tidx, m_rph, m_rbit;
    bit         m_tpend, m_tact, m_rbusy;
    logic [7:0] m_tbyte, m_acc, m_rdata;
    logic       m_line, m_tdone, m_rninth, m_rdone;
    bit         m_s1, m_s2, m_prev;
    bit [2:0]   m_smp;

    always @(posedge clk) begin
        bit sub, roll, fall, vote, set_t, set_r;
        if (rst) begin
            m_half = 0; m_tph = 0; m_tidx = 0; m_tpend = 0; m_tact = 0;
            m_tbyte = 0; m_line = 1; m_tdone = 0;
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_rbusy = 0; m_rph = 0; m_rbit = 0;
            m_smp = 0; m_acc = 0; m_rdata = 0; m_rninth = 0; m_rdone = 0;
        end else begin
            sub = baud_tick && (!slow_sel || m_half);
            if (baud_tick) m_half = !m_half;
            roll = sub && (m_tph == 15);
            if (sub) m_tph = (m_tph + 1) % 16;
            set_t = 0;
            if (m_tact && roll) begin
                if (m_tidx == 8) begin m_line = 1; m_tact = 0; set_t = 1; end
                else begin m_line = m_tbyte[m_tidx]; m_tidx++; end
            end else if (m_tpend && roll) begin
                m_line = 0; m_tpend = 0; m_tact = 1; m_tidx = 0;
            end else if (!m_tpend && !m_tact && tx_write) begin
                m_tpend = 1; m_tbyte = tx_wdata;
            end
            if (set_t) m_tdone = 1; else if (tx_done_clr) m_tdone = 0;

            fall = m_prev && !m_s2;
            set_r = 0;
            if (!m_rbusy) begin
                if (rx_enable && fall) begin m_rbusy = 1; m_rph = 0; m_rbit = 0; end
            end else if (sub) begin
                if (m_rph >= 7 && m_rph <= 9) m_smp[m_rph-7] = m_s2;
                if (m_rph == 9) begin
                    vote = ($countones(m_smp) >= 2);
                    if (m_rbit == 0) begin
                        if (vote) m_rbusy = 0; else m_rbit = 1;
                    end else if (m_rbit <= 8) begin
                        m_acc[m_rbit-1] = vote; m_rbit++;
                    end else begin
                        m_rbusy = 0;
                        if (!m_rdone && (!rx_filter || vote)) begin
                            m_rdata = m_acc; m_rninth = vote; set_r = 1;
                        end
                    end
                end
                m_rph = (m_rph + 1) % 16;
            end
            if (set_r) m_rdone = 1; else if (rx_done_clr) m_rdone = 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ser_in;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 ser_out vs model", ser_out, m_line);
            chk("R4 tx_done vs model", tx_done, m_tdone);
            chk("R9 rx_done vs model", rx_done, m_rdone);
            chk("R10 rx_data vs model", rx_data, m_rdata);
            chk("R10 rx_ninth vs model", rx_ninth, m_rninth);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d cycles expected=finish earlier", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic int bit_clks();
        return 16 * (slow_sel ? 2 : 1) * TICK_DIV;
    endfunction

    task automatic tx_send(input logic [7:0] d, output logic [7:0] got,
                           output logic stopv, output int delay);
        int spb;
        spb = bit_clks();
        tx_write = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_write = 1'b0;
        delay = 1;
        while (ser_out !== 1'b0 && delay < 5000) begin
            @(negedge clk);
            delay++;
        end
        repeat (spb / 2) @(negedge clk);
        chk("R2 start bit", ser_out, 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (spb) @(negedge clk);
            got[i] = ser_out;
        end
        repeat (spb) @(negedge clk);
        stopv = ser_out;
    endtask

    task automatic rx_send(input logic [7:0] d, input logic stopv,
                           input int stop_subs, input bit glitch);
        int spb;
        spb = bit_clks();
        ser_in = 1'b0;
        repeat (spb) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_in = d[i];
            if (glitch) begin
                repeat (17) @(negedge clk);
                ser_in = ~d[i];
                repeat (2) @(negedge clk);
                ser_in = d[i];
                repeat (spb - 19) @(negedge clk);
            end else begin
                repeat (spb) @(negedge clk);
            end
        end
        ser_in = stopv;
        repeat (stop_subs * (spb / 16)) @(negedge clk);
        ser_in = 1'b1;
    endtask

    task automatic clear_rx();
        rx_done_clr = 1'b1;
        @(negedge clk);
        rx_done_clr = 1'b0;
        @(negedge clk);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] got;
        logic       stopv;
        int         delay;
        logic [7:0] first;
        bit         stayed_high;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ser_out", ser_out, 1'b1);
        chk("R1 reset tx_done", tx_done, 1'b0);
        chk("R1 reset rx_done", rx_done, 1'b0);

        // transmit a byte
        tx_send(8'hA5, got, stopv, delay);
        chk("R2 tx byte", got, 8'hA5);
        chk("R2 tx stop", stopv, 1'b1);
        chk("R3 start within one wrap", (delay >= 1 && delay <= bit_clks() + 2), 1'b1);
        chk("R4 tx_done after stop", tx_done, 1'b1);
        tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0; @(negedge clk);
        chk("R4 tx_done cleared", tx_done, 1'b0);

        // write while busy is ignored
        fork
            tx_send(8'h3C, got, stopv, delay);
            begin
                repeat (60) @(negedge clk);
                tx_write = 1'b1; tx_wdata = 8'hFF;
                @(negedge clk);
                tx_write = 1'b0;
            end
        join
        chk("R5 byte unchanged by busy write", got, 8'h3C);
        stayed_high = 1;
        for (int i = 0; i < 3 * bit_clks(); i++) begin
            @(negedge clk);
            if (ser_out !== 1'b1) stayed_high = 0;
        end
        chk("R5 no extra character", stayed_high, 1'b1);
        tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0;

        // slow rate transmit
        slow_sel = 1'b1;
        repeat (4) @(negedge clk);
        tx_send(8'h81, got, stopv, delay);
        chk("R12 slow tx byte", got, 8'h81);
        chk("R12 slow tx stop", stopv, 1'b1);
        slow_sel = 1'b0;
        repeat (3 * 64) @(negedge clk);

        // receive disabled
        rx_enable = 1'b0;
        rx_send(8'h55, 1'b1, 16, 0);
        repeat (40) @(negedge clk);
        chk("R6 disabled no receive", rx_done, 1'b0);

        // plain receive
        rx_enable = 1'b1;
        rx_send(8'hA5, 1'b1, 16, 0);
        repeat (4) @(negedge clk);
        chk("R6 rx_done set", rx_done, 1'b1);
        chk("R10 rx_data", rx_data, 8'hA5);
        chk("R10 rx_ninth", rx_ninth, 1'b1);
        clear_rx();
        chk("R10 rx_done cleared", rx_done, 1'b0);

        // single-sample disturbance in every data bit
        rx_send(8'h96, 1'b1, 16, 1);
        repeat (4) @(negedge clk);
        chk("R7 majority vote byte", rx_data, 8'h96);
        chk("R7 majority vote flag", rx_done, 1'b1);
        clear_rx();

        // false start
        ser_in = 1'b0;
        repeat (6) @(negedge clk);
        ser_in = 1'b1;
        repeat (400) @(negedge clk);
        chk("R8 false start no flag", rx_done, 1'b0);
        rx_send(8'h3C, 1'b1, 16, 0);
        repeat (4) @(negedge clk);
        chk("R8 next frame after false start", rx_data, 8'h3C);

        // flag still set: character dropped
        rx_send(8'h11, 1'b0, 16, 0);
        repeat (4) @(negedge clk);
        chk("R9 full flag drops data", rx_data, 8'h3C);
        chk("R9 full flag drops ninth", rx_ninth, 1'b1);
        clear_rx();

        // filter on, stop bit 0: dropped
        rx_filter = 1'b1;
        rx_send(8'h22, 1'b0, 16, 0);
        repeat (4) @(negedge clk);
        chk("R9 filter drops low stop flag", rx_done, 1'b0);
        chk("R9 filter drops low stop data", rx_data, 8'h3C);

        // filter on, stop bit 1: kept
        rx_send(8'h44, 1'b1, 16, 0);
        repeat (4) @(negedge clk);
        chk("R9 filter keeps high stop", rx_data, 8'h44);
        clear_rx();

        // filter off, stop bit 0: kept with ninth 0
        rx_filter = 1'b0;
        rx_send(8'h66, 1'b0, 16, 0);
        repeat (4) @(negedge clk);
        chk("R10 low stop kept data", rx_data, 8'h66);
        chk("R10 low stop kept ninth", rx_ninth, 1'b0);
        clear_rx();

        // back-to-back with a short stop bit
        first = 8'h00;
        fork
            begin
                rx_send(8'h12, 1'b1, 14, 0);
                rx_send(8'h34, 1'b1, 16, 0);
            end
            begin
                while (rx_done !== 1'b1) @(negedge clk);
                first = rx_data;
                rx_done_clr = 1'b1;
                @(negedge clk);
                rx_done_clr = 1'b0;
            end
        join
        repeat (4) @(negedge clk);
        chk("R11 first of pair", first, 8'h12);
        chk("R11 second of pair", rx_data, 8'h34);
        clear_rx();

        // slow rate receive
        slow_sel = 1'b1;
        repeat (4) @(negedge clk);
        rx_send(8'hC3, 1'b1, 16, 0);
        repeat (6) @(negedge clk);
        chk("R12 slow rx byte", rx_data, 8'hC3);
        chk("R12 slow rx flag", rx_done, 1'b1);

        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule